// File: doc/BRIEF.md
# Strobe-Synchronized Asynchronous Memory Slave

This block lets an external host reach a bank of 16-bit registers through an asynchronous, non-multiplexed, NOR-style memory bus. The block runs on its own oscillator, which has no fixed relation to the host's clock. The chip-select, output-enable and write-enable strobes (all active low) each pass through a two-stage synchronizer. No address-valid strobe exists on this bus, so the address is captured when the synchronized chip select is first seen active.

The host cannot know how long the slave needs, so the slave raises a WAIT line just after it latches the address. For a read, the slave drives data onto the bus first and only then drops WAIT. For a write, WAIT holds the host's data steady until the register has taken it. The data bus is split into an input, an output and an output enable, which the pad ring combines into one tri-state bus. Read data stays on the bus until the slave sees the host's strobe go inactive through the synchronizer.

Top module: `nor_strobe_slave`

## Requirements
- R1: After reset, WAIT and the data output enable are low, and every register reads back as 0x0000.
- R2: WAIT rises exactly three rising slave-clock edges after chip select goes low, while the strobes are otherwise idle. It stays high until the access has been served.
- R3: The address is captured when the synchronized chip select becomes active. Changing the address afterwards within the same access has no effect on which register is read.
- R4: In a read, the data output enable is high and the read word is on data_o for at least one slave cycle before WAIT falls.
- R5: Read data stays driven while output enable stays low. The output enable returns low exactly two rising slave edges after output enable (or chip select) rises.
- R6: A write takes effect on the synchronized falling edge of write enable while chip select is low. It updates the register at the latched address with data_i, and WAIT falls only after the capture.
- R7: When output enable and write enable fall together in one access, the access is a read. The write strobe is ignored and the register keeps its old value.
- R8: After an access is served, no new WAIT assertion and no bus drive occur until chip select has been seen high, even if the strobes pulse again.
- R9: The data output enable stays low for the whole of a write access.
- R10: Each register is addressed independently: a write to one address does not change any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slave clock, unrelated to the host |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select from host, active low, asynchronous |
| oe_n_i | input | 1 | Output enable from host, active low, asynchronous |
| we_n_i | input | 1 | Write enable from host, active low, asynchronous |
| addr_i | input | ADDR_W (4) | Register address from host |
| data_i | input | DATA_W (16) | Write data from the bus pads |
| data_o | output | DATA_W (16) | Read data toward the bus pads |
| data_oe_o | output | 1 | Pad output enable for data_o |
| host_wait_o | output | 1 | WAIT to host, high while the access is not yet served |

## Verification
A controller stuck outside its idle state shows up at the next access: WAIT does not rise on the third edge, or the bus is never driven. A controller that re-arms without seeing chip select high shows up within a few cycles as a stray WAIT pulse on a repeated strobe. A wrong latched address or a misdecoded write shows up as a wrong word on the very next read-back. A release that comes a cycle early or late shows up in the exact edge count of the output enable after the strobe rises.

// File: rtl/nors_pkg.sv
package nors_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LATCH   = 3'd1,
        ST_BUSY    = 3'd2,
        ST_READY   = 3'd3,
        ST_RELEASE = 3'd4
    } nors_state_e;
endpackage

// File: rtl/nors_sync.sv
module nors_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
            else         chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/nors_regbank.sv
module nors_regbank #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic [DATA_W-1:0] word_d;

        always_comb begin
            word_d = mem_q[i];
            if (wr_en_i && (addr_i == ADDR_W'(i))) word_d = wdata_i;
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) mem_q[i] <= '0;
            else         mem_q[i] <= word_d;
        end
    end

    assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/nors_ctrl.sv
module nors_ctrl
    import nors_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_act_i,
    input  logic              oe_act_i,
    input  logic              we_act_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] bank_rdata_i,
    output logic [ADDR_W-1:0] bank_addr_o,
    output logic              bank_wr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              stall_o
);
    typedef struct packed {
        nors_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic              stall;
        logic              drive;
        logic              is_rd;
        logic              we_prev;
        logic [DATA_W-1:0] rd_word;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  wr_d;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.we_prev = we_act_i;
        wr_d          = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.is_rd = 1'b0;
                ctl_d.drive = 1'b0;
                if (cs_act_i) begin
                    ctl_d.st   = ST_LATCH;
                    ctl_d.addr = addr_i;
                end
            end
            ST_LATCH: begin
                ctl_d.st = cs_act_i ? ST_BUSY : ST_RELEASE;
            end
            ST_BUSY: begin
                if (!cs_act_i) begin
                    ctl_d.st = ST_RELEASE;
                end else if (oe_act_i) begin
                    ctl_d.st      = ST_READY;
                    ctl_d.is_rd   = 1'b1;
                    ctl_d.drive   = 1'b1;
                    ctl_d.rd_word = bank_rdata_i;
                end else if (we_act_i && !ctl_q.we_prev) begin
                    wr_d     = 1'b1;
                    ctl_d.st = ST_READY;
                end
            end
            ST_READY: begin
                if (!cs_act_i || (ctl_q.is_rd ? !oe_act_i : !we_act_i)) begin
                    ctl_d.st    = ST_RELEASE;
                    ctl_d.drive = 1'b0;
                end
            end
            ST_RELEASE: begin
                ctl_d.drive = 1'b0;
                if (!cs_act_i) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        ctl_d.stall = (ctl_d.st == ST_LATCH) || (ctl_d.st == ST_BUSY) ||
                      ((ctl_d.st == ST_READY) && (ctl_q.st != ST_READY));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bank_addr_o = ctl_q.addr;
    assign bank_wr_o   = wr_d;
    assign data_o      = ctl_q.rd_word;
    assign data_oe_o   = ctl_q.drive & oe_act_i & cs_act_i;
    assign stall_o     = ctl_q.stall;

    // R2: WAIT only rises after chip select was seen active
    p_wait_after_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ctl_q.stall) |-> $past(cs_act_i));

    // R3: latched address is frozen once an access has begun
    p_addr_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st != ST_IDLE && $past(ctl_q.st) != ST_IDLE) |-> $stable(ctl_q.addr));

    // R4: read data is driven in the cycle before WAIT falls
    p_data_before_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(ctl_q.stall) && ctl_q.is_rd) |-> $past(ctl_q.drive));

    // R6 / R9: a write is captured under WAIT and never while driving
    p_write_under_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bank_wr_o |-> (ctl_q.stall && !ctl_q.drive));

    // R8: no re-arm while chip select is still active after an access
    p_no_rearm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st == ST_RELEASE && cs_act_i) |=> !ctl_q.stall);
endmodule

// File: rtl/nor_strobe_slave.sv
module nor_strobe_slave #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              host_wait_o
);
    localparam int N_STROBES = 3;

    logic [N_STROBES-1:0] strobe_s;
    logic [ADDR_W-1:0]    bank_addr;
    logic                 bank_wr;
    logic [DATA_W-1:0]    bank_rdata;

    nors_sync #(
        .WIDTH  (N_STROBES),
        .STAGES (2),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i({we_n_i, oe_n_i, cs_n_i}),
        .sync_o (strobe_s)
    );

    nors_regbank #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_bank (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_en_i(bank_wr),
        .addr_i (bank_addr),
        .wdata_i(data_i),
        .rdata_o(bank_rdata)
    );

    nors_ctrl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cs_act_i    (~strobe_s[0]),
        .oe_act_i    (~strobe_s[1]),
        .we_act_i    (~strobe_s[2]),
        .addr_i      (addr_i),
        .bank_rdata_i(bank_rdata),
        .bank_addr_o (bank_addr),
        .bank_wr_o   (bank_wr),
        .data_o      (data_o),
        .data_oe_o   (data_oe_o),
        .stall_o     (host_wait_o)
    );
endmodule

// File: tb/nor_strobe_slave_bench.sv
module nor_strobe_slave_bench;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int NV = 10;

    // vector: {is_write, addr, data}; for reads, data is the expected word
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 4'd3,  16'hA5C3},
        {1'b1, 4'd7,  16'h1234},
        {1'b1, 4'd15, 16'hFFFF},
        {1'b1, 4'd0,  16'h8001},
        {1'b0, 4'd3,  16'hA5C3},
        {1'b0, 4'd7,  16'h1234},
        {1'b0, 4'd15, 16'hFFFF},
        {1'b0, 4'd0,  16'h8001},
        {1'b0, 4'd5,  16'h0000},
        {1'b0, 4'd14, 16'h0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          data_oe, hwait;
    int            tests = 0, fails = 0;

    always #2 clk = ~clk;

    nor_strobe_slave #(.ADDR_W(AW), .DATA_W(DW)) u_nor_strobe_slave (
        .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .oe_n_i(oe_n), .we_n_i(we_n),
        .addr_i(addr), .data_i(wdata), .data_o(rdata), .data_oe_o(data_oe),
        .host_wait_o(hwait)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_for(input logic v);
        int n = 0;
        while (hwait !== v && n < 50) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [AW-1:0] late_a,
                           output logic [DW-1:0] d);
        bit pre = 1'b0;
        int n = 0;
        @(negedge clk);
        addr = a;
        cs_n = 1'b0;
        wait_for(1'b1);
        chk("R2 wait raised for read", 32'(hwait), 32'd1);
        addr = late_a;
        @(negedge clk);
        oe_n = 1'b0;
        while (hwait !== 1'b0 && n < 50) begin
            @(negedge clk);
            if (hwait === 1'b1 && data_oe === 1'b1) pre = 1'b1;
            n++;
        end
        chk("R4 bus driven before wait fell", 32'(pre), 32'd1);
        d = rdata;
        oe_n = 1'b1;
        cs_n = 1'b1;
        @(negedge clk);
        chk("R5 still driven one edge after strobe rise", 32'(data_oe), 32'd1);
        @(negedge clk);
        chk("R5 released two edges after strobe rise", 32'(data_oe), 32'd0);
        idle(6);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bit drove = 1'b0;
        int n = 0;
        @(negedge clk);
        addr = a;
        wdata = d;
        cs_n = 1'b0;
        wait_for(1'b1);
        @(negedge clk);
        we_n = 1'b0;
        while (hwait !== 1'b0 && n < 50) begin
            @(negedge clk);
            if (data_oe === 1'b1) drove = 1'b1;
            n++;
        end
        chk("R6 wait released after write", 32'(hwait), 32'd0);
        we_n = 1'b1;
        cs_n = 1'b1;
        @(negedge clk);
        wdata = 16'hDEAD;
        chk("R9 bus not driven in write", 32'(drove), 32'd0);
        idle(6);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] got;
        bit seen;
        repeat (3) @(negedge clk);
        chk("R1 wait low in reset", 32'(hwait), 32'd0);
        chk("R1 bus idle in reset", 32'(data_oe), 32'd0);
        rst_n = 1'b1;
        idle(2);
        do_read(4'd9, 4'd9, got);
        chk("R1 register zero after reset", 32'(got), 32'h0);

        // R2: exact edge count from chip select to WAIT
        @(negedge clk);
        addr = 4'd2;
        cs_n = 1'b0;
        @(negedge clk);
        chk("R2 wait low after 1 edge", 32'(hwait), 32'd0);
        @(negedge clk);
        chk("R2 wait low after 2 edges", 32'(hwait), 32'd0);
        @(negedge clk);
        chk("R2 wait high after 3 edges", 32'(hwait), 32'd1);
        cs_n = 1'b1;
        idle(8);
        chk("R2 wait dropped after aborted access", 32'(hwait), 32'd0);

        // table walk: writes then read-backs (R6, R10)
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) begin
                do_write(VEC[i][19:16], VEC[i][15:0]);
            end else begin
                do_read(VEC[i][19:16], VEC[i][19:16], got);
                chk($sformatf("R10 read-back addr %0d", VEC[i][19:16]), 32'(got),
                    32'(VEC[i][15:0]));
            end
        end

        // R3: address change after latch is ignored
        do_read(4'd3, 4'd7, got);
        chk("R3 latched address used", 32'(got), 32'hA5C3);

        // R7: simultaneous OE and WE is a read, write ignored
        @(negedge clk);
        addr = 4'd7;
        wdata = 16'h5555;
        cs_n = 1'b0;
        wait_for(1'b1);
        @(negedge clk);
        oe_n = 1'b0;
        we_n = 1'b0;
        wait_for(1'b0);
        chk("R7 collision returns read data", 32'(rdata), 32'h1234);
        chk("R7 collision drives bus", 32'(data_oe), 32'd1);
        oe_n = 1'b1;
        we_n = 1'b1;
        cs_n = 1'b1;
        idle(8);
        do_read(4'd7, 4'd7, got);
        chk("R7 register unchanged by ignored write", 32'(got), 32'h1234);

        // R8: no re-arm while chip select stays low
        @(negedge clk);
        addr = 4'd15;
        cs_n = 1'b0;
        wait_for(1'b1);
        @(negedge clk);
        oe_n = 1'b0;
        wait_for(1'b0);
        chk("R8 first read served", 32'(rdata), 32'hFFFF);
        oe_n = 1'b1;
        idle(6);
        oe_n = 1'b0;
        we_n = 1'b0;
        seen = 1'b0;
        repeat (8) begin
            @(negedge clk);
            if (hwait === 1'b1 || data_oe === 1'b1) seen = 1'b1;
        end
        chk("R8 no wait or drive before chip select high", 32'(seen), 32'd0);
        oe_n = 1'b1;
        we_n = 1'b1;
        cs_n = 1'b1;
        idle(8);
        do_read(4'd15, 4'd15, got);
        chk("R8 register untouched by repeated strobes", 32'(got), 32'hFFFF);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule